// File: doc/BRIEF.md
# Auto-Advancing Circular Byte Queue Bank

This block holds a set of byte-wide circular queues inside one shared on-chip RAM. A host processor reaches them only through a small window of bus addresses called hotspots. It never sees the RAM directly. Each queue owns two hotspots. Reading its data hotspot returns the byte at the queue's current index, and writing it stores a byte there. Either access then moves the index forward by one. When the index passes the queue's loop end, it wraps back to the queue's base. The queue's seek hotspot takes a written byte as the new index. A few group seek hotspots, plus one global seek hotspot, reposition many queues in a single bus write.

The base address, the loop end and the group membership of each queue come from a separate configuration port that is used while a program is loaded. The data path is transparent: the byte returned is exactly the byte that was stored. A kernel can therefore stream display or sample data with one load per item and no index arithmetic.

Top module: `qbank_top`

## Requirements
- R1: A read strobe at bus address q (0 to 15) raises `rd_valid` for exactly one cycle in the following cycle. In that cycle `rd_data` carries the byte stored at RAM location (base + index) mod 4096 of queue q, unchanged, and the index of queue q then advances by one.
- R2: A write strobe at bus address q (0 to 15) stores `bus_wdata` at RAM location (base + index) mod 4096 of queue q and advances that queue's index by one, just as a read does.
- R3: When a queue's index is equal to or greater than its loop end, the next data access moves the index to 0, so the next byte comes from the queue's base.
- R4: A write to bus address 16 + q loads `bus_wdata` (0 to 255) as the index of queue q only. A value of 0 rewinds the queue to its base.
- R5: A write to bus address 32 + g (g from 0 to 3) loads `bus_wdata` as the index of every queue whose group mask has bit g set. A write to bus address 36 loads it into every queue. Queues outside the group keep their index.
- R6: Pointers and `rd_valid` are left unchanged by cycles without `bus_strobe`, by strobes at addresses 37 to 63, and by reads of the seek and group hotspots (16 to 36). None of these cycles produces `rd_valid`.
- R7: A `cfg_we` pulse sets the base, the loop end and the 4-bit group mask of queue `cfg_sel`, and it clears that queue's index to 0. If a bus data access to the same queue arrives in the same cycle, the access still transfers its byte at the old position, but the index ends at 0.
- R8: After reset every index is 0, queue q has base q*256, loop end 255 and an empty group mask, and `rd_valid` is low.
- R9: A queue whose loop end is above 255 can only be seeked to indices 0 to 255. It still advances past 255 up to its loop end and then wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_strobe | input | 1 | Single-cycle host access qualifier |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 6 | Hotspot address |
| bus_wdata | input | 8 | Write data or seek value |
| rd_data | output | 8 | Byte read from a data hotspot |
| rd_valid | output | 1 | rd_data is valid this cycle |
| cfg_we | input | 1 | Load-time configuration write |
| cfg_sel | input | 4 | Queue being configured |
| cfg_base | input | 12 | RAM base of the queue |
| cfg_last | input | 12 | Loop end index of the queue |
| cfg_groups | input | 4 | Group membership mask |

## Verification
The hardest case to reach from the ports is a loop longer than 256 bytes. There, the index has to be carried above the seekable range purely by advancing, and it has to wrap at an end that no seek can reach directly. The stimulus configures such a queue over the region of its neighbours, seeks it near 255 and streams several hundred reads. It compares each byte with a byte-accurate model of the RAM, which was filled earlier through the data hotspots of all queues. A configuration write that collides with a data access to the same queue is also driven on purpose, so that both the old-position byte and the cleared index can be seen.

// File: rtl/qbank_pkg.sv
`timescale 1ns/1ps
package qbank_pkg;

  // Per-queue pointer command, resolved once per cycle in the top level.
  typedef enum logic [1:0] {
    QC_HOLD = 2'd0,
    QC_ADV  = 2'd1,
    QC_SEEK = 2'd2,
    QC_LOAD = 2'd3
  } qcmd_e;

endpackage

// File: rtl/qbank_decode.sv
`timescale 1ns/1ps
module qbank_decode #(
  parameter int NUM_Q   = 16,
  parameter int NUM_GRP = 4,
  parameter int BUS_AW  = 6
) (
  input  logic               strobe,
  input  logic               we,
  input  logic [BUS_AW-1:0]  addr,
  output logic [NUM_Q-1:0]   data_oh,
  output logic [NUM_Q-1:0]   seek_oh,
  output logic [NUM_GRP-1:0] grp_oh,
  output logic               all_hit,
  output logic               data_rd
);

  localparam int SEEK_BASE = NUM_Q;
  localparam int GRP_BASE  = 2 * NUM_Q;
  localparam int ALL_ADDR  = GRP_BASE + NUM_GRP;

  int a;

  always_comb begin
    a       = int'(addr);
    data_oh = '0;
    seek_oh = '0;
    grp_oh  = '0;
    all_hit = 1'b0;
    data_rd = 1'b0;
    if (strobe) begin
      if (a < SEEK_BASE) begin
        data_oh[a] = 1'b1;
        data_rd    = ~we;
      end else if (we) begin
        if (a < GRP_BASE) begin
          seek_oh[a - SEEK_BASE] = 1'b1;
        end else if (a < ALL_ADDR) begin
          grp_oh[a - GRP_BASE] = 1'b1;
        end else if (a == ALL_ADDR) begin
          all_hit = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/qbank_qctl.sv
`timescale 1ns/1ps
module qbank_qctl
  import qbank_pkg::*;
#(
  parameter int Q_IDX   = 0,
  parameter int Q_DEPTH = 256,
  parameter int NUM_GRP = 4,
  parameter int MA_W    = 12,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  qcmd_e              cmd,
  input  logic [DW-1:0]      seek_val,
  input  logic [MA_W-1:0]    cfg_base,
  input  logic [MA_W-1:0]    cfg_last,
  input  logic [NUM_GRP-1:0] cfg_groups,
  output logic [MA_W-1:0]    idx,
  output logic [MA_W-1:0]    base,
  output logic [NUM_GRP-1:0] groups
);

  localparam logic [MA_W-1:0] RST_BASE = MA_W'(Q_IDX * Q_DEPTH);
  localparam logic [MA_W-1:0] RST_LAST = MA_W'(Q_DEPTH - 1);

  logic [MA_W-1:0]    idx_q, idx_d;
  logic [MA_W-1:0]    base_q, base_d;
  logic [MA_W-1:0]    last_q, last_d;
  logic [NUM_GRP-1:0] grp_q, grp_d;
  logic               idx_en, cfg_en;

  always_comb begin
    idx_d  = idx_q;
    base_d = base_q;
    last_d = last_q;
    grp_d  = grp_q;
    idx_en = 1'b0;
    cfg_en = 1'b0;
    unique case (cmd)
      QC_LOAD: begin
        base_d = cfg_base;
        last_d = cfg_last;
        grp_d  = cfg_groups;
        idx_d  = '0;
        idx_en = 1'b1;
        cfg_en = 1'b1;
      end
      QC_SEEK: begin
        idx_d  = MA_W'(seek_val);
        idx_en = 1'b1;
      end
      QC_ADV: begin
        idx_d  = (idx_q >= last_q) ? '0 : idx_q + 1'b1;
        idx_en = 1'b1;
      end
      default: begin
        idx_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= RST_BASE;
      last_q <= RST_LAST;
      grp_q  <= '0;
    end else if (cfg_en) begin
      base_q <= base_d;
      last_q <= last_d;
      grp_q  <= grp_d;
    end
  end

  assign idx    = idx_q;
  assign base   = base_q;
  assign groups = grp_q;

endmodule

// File: rtl/qbank_ram.sv
`timescale 1ns/1ps
module qbank_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 4096,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en && we) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (en && !we) begin
      rdata_q <= mem[addr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/qbank_top.sv
`timescale 1ns/1ps
module qbank_top
  import qbank_pkg::*;
#(
  parameter int NUM_Q   = 16,
  parameter int Q_DEPTH = 256,
  parameter int NUM_GRP = 4,
  parameter int DW      = 8,
  parameter int BUS_AW  = 6,
  localparam int MEM_DEPTH = NUM_Q * Q_DEPTH,
  localparam int MA_W      = $clog2(MEM_DEPTH),
  localparam int QS_W      = $clog2(NUM_Q)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_strobe,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      rd_data,
  output logic               rd_valid,
  input  logic               cfg_we,
  input  logic [QS_W-1:0]    cfg_sel,
  input  logic [MA_W-1:0]    cfg_base,
  input  logic [MA_W-1:0]    cfg_last,
  input  logic [NUM_GRP-1:0] cfg_groups
);

  logic [NUM_Q-1:0]   data_oh, seek_oh;
  logic [NUM_GRP-1:0] grp_oh;
  logic               all_hit, data_rd;

  logic [MA_W-1:0]    idx_a  [NUM_Q];
  logic [MA_W-1:0]    base_a [NUM_Q];
  logic [NUM_GRP-1:0] grp_a  [NUM_Q];
  qcmd_e              cmd_a  [NUM_Q];
  logic [NUM_Q*MA_W-1:0] idx_flat;

  logic [MA_W-1:0] sel_base, sel_idx, ram_addr;
  logic            ram_en;
  logic            rd_valid_q, rd_valid_d;

  qbank_decode #(
    .NUM_Q  (NUM_Q),
    .NUM_GRP(NUM_GRP),
    .BUS_AW (BUS_AW)
  ) u_decode (
    .strobe (bus_strobe),
    .we     (bus_we),
    .addr   (bus_addr),
    .data_oh(data_oh),
    .seek_oh(seek_oh),
    .grp_oh (grp_oh),
    .all_hit(all_hit),
    .data_rd(data_rd)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    logic cfg_hit, seek_hit;

    assign cfg_hit  = cfg_we && (cfg_sel == QS_W'(q));
    assign seek_hit = seek_oh[q] || all_hit || ((grp_oh & grp_a[q]) != '0);

    always_comb begin
      if (cfg_hit)         cmd_a[q] = QC_LOAD;
      else if (seek_hit)   cmd_a[q] = QC_SEEK;
      else if (data_oh[q]) cmd_a[q] = QC_ADV;
      else                 cmd_a[q] = QC_HOLD;
    end

    qbank_qctl #(
      .Q_IDX  (q),
      .Q_DEPTH(Q_DEPTH),
      .NUM_GRP(NUM_GRP),
      .MA_W   (MA_W),
      .DW     (DW)
    ) u_qctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd_a[q]),
      .seek_val  (bus_wdata),
      .cfg_base  (cfg_base),
      .cfg_last  (cfg_last),
      .cfg_groups(cfg_groups),
      .idx       (idx_a[q]),
      .base      (base_a[q]),
      .groups    (grp_a[q])
    );

    assign idx_flat[q*MA_W +: MA_W] = idx_a[q];
  end

  // One-hot select of the accessed queue's position.
  always_comb begin
    sel_base = '0;
    sel_idx  = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      sel_base = sel_base | (base_a[q] & {MA_W{data_oh[q]}});
      sel_idx  = sel_idx  | (idx_a[q]  & {MA_W{data_oh[q]}});
    end
  end

  assign ram_addr = sel_base + sel_idx;
  assign ram_en   = |data_oh;

  qbank_ram #(
    .DW   (DW),
    .DEPTH(MEM_DEPTH),
    .AW   (MA_W)
  ) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (bus_we),
    .addr (ram_addr),
    .wdata(bus_wdata),
    .rdata(rd_data)
  );

  assign rd_valid_d = data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
    end
  end

  assign rd_valid = rd_valid_q;

endmodule

// File: rtl/qbank_chk.sv
`timescale 1ns/1ps
module qbank_chk #(
  parameter int NUM_Q   = 16,
  parameter int NUM_GRP = 4,
  parameter int MA_W    = 12,
  parameter int QS_W    = 4,
  parameter int BUS_AW  = 6,
  parameter int DW      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_strobe,
  input logic                  bus_we,
  input logic [BUS_AW-1:0]     bus_addr,
  input logic [DW-1:0]         bus_wdata,
  input logic                  cfg_we,
  input logic [QS_W-1:0]       cfg_sel,
  input logic                  rd_valid,
  input logic [NUM_Q*MA_W-1:0] idx_flat
);

  localparam int WIN_LAST = 2 * NUM_Q + NUM_GRP;

  logic [QS_W-1:0] cfg_sel_q;
  logic [QS_W-1:0] seek_tgt_q;
  logic            is_data_rd, is_seek, is_outside;

  assign is_data_rd = bus_strobe && !bus_we && (int'(bus_addr) < NUM_Q);
  assign is_seek    = bus_strobe && bus_we && (int'(bus_addr) >= NUM_Q)
                      && (int'(bus_addr) < 2 * NUM_Q) && !cfg_we;
  assign is_outside = bus_strobe && (int'(bus_addr) > WIN_LAST) && !cfg_we;

  always_ff @(posedge clk) begin
    cfg_sel_q  <= cfg_sel;
    seek_tgt_q <= QS_W'(int'(bus_addr) - NUM_Q);
  end

  // R1: a data-hotspot read yields rd_valid next cycle
  a_r1_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    is_data_rd |=> rd_valid);

  // R6: rd_valid only follows a data-hotspot read
  a_r6_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !is_data_rd |=> !rd_valid);

  // R6: idle cycles leave every index alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_strobe && !cfg_we) |=> $stable(idx_flat));

  // R6: strobes outside the hotspot window leave every index alone
  a_r6_outside_hold: assert property (@(posedge clk) disable iff (!rst_n)
    is_outside |=> $stable(idx_flat));

  // R7: configuration clears the selected queue's index
  a_r7_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (idx_flat[cfg_sel_q*MA_W +: MA_W] == '0));

  // R4: a seek write loads the data byte as the target index
  a_r4_seek_load: assert property (@(posedge clk) disable iff (!rst_n)
    is_seek |=> (idx_flat[seek_tgt_q*MA_W +: MA_W] == MA_W'($past(bus_wdata))));

endmodule

bind qbank_top qbank_chk #(
  .NUM_Q  (NUM_Q),
  .NUM_GRP(NUM_GRP),
  .MA_W   (MA_W),
  .QS_W   (QS_W),
  .BUS_AW (BUS_AW),
  .DW     (DW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_strobe(bus_strobe),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .rd_valid  (rd_valid),
  .idx_flat  (idx_flat)
);

// File: tb/tb_qbank_top.sv
`timescale 1ns/1ps
module tb_qbank_top;

  localparam int NQ   = 16;
  localparam int MEMN = 4096;

  logic       clk, rst_n;
  logic       bus_strobe, bus_we;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       cfg_we;
  logic [3:0] cfg_sel;
  logic [11:0] cfg_base, cfg_last;
  logic [3:0] cfg_groups;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int mmem  [MEMN];
  int midx  [NQ];
  int mbase [NQ];
  int mlast [NQ];
  int mgrp  [NQ];

  qbank_top dut (
    .clk(clk), .rst_n(rst_n),
    .bus_strobe(bus_strobe), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
    .cfg_last(cfg_last), .cfg_groups(cfg_groups)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int pat(int q, int i);
    return (q * 37 + i * 5 + 11) & 255;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic madv(int q);
    midx[q] = (midx[q] >= mlast[q]) ? 0 : midx[q] + 1;
  endtask

  task automatic acc(bit we, int addr, int wd);
    bus_strobe = 1'b1;
    bus_we     = we;
    bus_addr   = 6'(addr);
    bus_wdata  = 8'(wd);
    @(negedge clk);
    bus_strobe = 1'b0;
    bus_we     = 1'b0;
  endtask

  task automatic qread(int q, string req);
    int exp;
    exp = mmem[(mbase[q] + midx[q]) % MEMN];
    acc(1'b0, q, 0);
    chk(req, int'(rd_valid), 1);
    chk(req, int'(rd_data), exp);
    madv(q);
  endtask

  task automatic qwrite(int q, int v);
    mmem[(mbase[q] + midx[q]) % MEMN] = v;
    acc(1'b1, q, v);
    madv(q);
  endtask

  task automatic qcfg(int q, int b, int l, int g);
    cfg_we = 1'b1; cfg_sel = 4'(q);
    cfg_base = 12'(b); cfg_last = 12'(l); cfg_groups = 4'(g);
    @(negedge clk);
    cfg_we = 1'b0;
    mbase[q] = b; mlast[q] = l; mgrp[q] = g; midx[q] = 0;
  endtask

  task automatic gseek(int g, int v);
    acc(1'b1, 32 + g, v);
    for (int q = 0; q < NQ; q++) if (((mgrp[q] >> g) & 1) != 0) midx[q] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e;
    rst_n = 1'b0; bus_strobe = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_base = '0;
    cfg_last = '0; cfg_groups = '0;
    for (int q = 0; q < NQ; q++) begin
      midx[q] = 0; mbase[q] = q * 256; mlast[q] = 255; mgrp[q] = 0;
    end
    for (int a = 0; a < MEMN; a++) mmem[a] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 rd_valid low", int'(rd_valid), 0);

    // R2/R8: fill every queue through its data hotspot from reset position
    for (int q = 0; q < NQ; q++)
      for (int i = 0; i < 256; i++) qwrite(q, pat(q, i));
    // R1: stream back every byte; R3: index wrapped to base after 256
    for (int q = 0; q < NQ; q++)
      for (int i = 0; i < 256; i++) begin
        chk("R1 model index", midx[q], i);
        qread(q, "R1 stream");
      end
    for (int q = 0; q < NQ; q++) begin
      e = pat(q, 0);
      acc(1'b0, q, 0);
      chk("R3 wrap to base", int'(rd_data), e);
      madv(q);
    end

    // R4: single seeks on every queue
    for (int q = 0; q < NQ; q++) begin
      acc(1'b1, 16 + q, q * 13 + 7);
      midx[q] = q * 13 + 7;
      qread(q, "R4 seek");
    end

    // R3/R7: short loop of 10 on queue 3, then runtime rewrite
    qcfg(3, 'h300, 9, 0);
    for (int i = 0; i < 25; i++) qread(3, "R3 short loop");
    acc(1'b1, 16 + 3, 0); midx[3] = 0;
    for (int i = 0; i < 4; i++) qwrite(3, 200 + i);
    acc(1'b1, 16 + 3, 0); midx[3] = 0;
    for (int i = 0; i < 6; i++) qread(3, "R2 rewrite");

    // R9: long loop of 600 on queue 5
    qcfg(5, 'h500, 599, 0);
    acc(1'b1, 16 + 5, 250); midx[5] = 250;
    for (int i = 0; i < 400; i++) qread(5, "R9 long loop");
    acc(1'b1, 16 + 5, 255); midx[5] = 255;
    qread(5, "R9 max seek");

    // R5: groups
    qcfg(0, 'h000, 255, 'b0010);
    qcfg(1, 'h100, 255, 'b0011);
    qcfg(2, 'h200, 255, 'b0010);
    for (int q = 0; q < 5; q++) begin qread(q, "R5 pre"); qread(q, "R5 pre"); end
    gseek(1, 7);
    for (int q = 0; q < 5; q++) qread(q, "R5 group1 seek");
    gseek(0, 100);
    qread(0, "R5 non-member hold");
    qread(1, "R5 group0 seek");
    acc(1'b1, 36, 3);
    for (int q = 0; q < NQ; q++) midx[q] = 3;
    for (int q = 0; q < NQ; q++) qread(q, "R5 global seek");

    // R6: ignored accesses
    acc(1'b0, 40, 0);
    chk("R6 outside no valid", int'(rd_valid), 0);
    acc(1'b1, 37, 9);
    chk("R6 unused write no valid", int'(rd_valid), 0);
    acc(1'b0, 16 + 2, 0);
    chk("R6 seek read no valid", int'(rd_valid), 0);
    acc(1'b0, 34, 0);
    chk("R6 group read no valid", int'(rd_valid), 0);
    bus_addr = 6'd2;
    repeat (3) @(negedge clk);
    chk("R6 idle no valid", int'(rd_valid), 0);
    for (int q = 0; q < NQ; q++) qread(q, "R6 index held");

    // R7: config collides with a read of the same queue
    e = mmem[(mbase[8] + midx[8]) % MEMN];
    cfg_we = 1'b1; cfg_sel = 4'd8; cfg_base = 12'h800;
    cfg_last = 12'd255; cfg_groups = 4'd0;
    acc(1'b0, 8, 0);
    cfg_we = 1'b0;
    mbase[8] = 'h800; mlast[8] = 255; mgrp[8] = 0; midx[8] = 0;
    chk("R7 collision old byte", int'(rd_data), e);
    qread(8, "R7 index cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule